// File: doc/BRIEF.md
# Bitwise Majority-Vote Median Filter

This block returns the median of the last M unsigned N-bit samples it has accepted. Every sample offered with the valid strobe enters a window of M registers, and the oldest entry leaves it. The median is never found by sorting or by comparing samples with one another. It is built one bit at a time, from the most significant bit down. Each result bit is the majority vote of one bit column of the window.

Once a sample's bit disagrees with the median bit chosen at some stage, that sample is known to lie wholly above or wholly below the median. From then on it keeps voting with the bit it had where it split off. A small per-sample state (a "split" flag and a "held" bit) carries this information from one stage to the next. The stages are either all combinational, giving a result in the cycle after the sample is accepted, or separated by a register level after every bit, giving an N-cycle latency and a short path per stage for wide windows.

Top module: `median_filter`

## Requirements
- R1: After reset, medVld stays 0 until M samples have been accepted (inVld high at a rising edge). Each of those accepts counts toward filling the window.
- R2: A cycle with inVld low shifts nothing into the window and produces no result. The window always holds exactly the last M accepted samples.
- R3: Every result equals the median of the window: the value at position (M+1)/2 of the M samples sorted in ascending order, with repeated values counted separately. medOut is unsigned and bit N-1 is its most significant bit.
- R4: When all M samples in the window are equal, including all zeros and all ones, the result equals that value.
- R5: With PIPELINED=1, the edge that accepts a sample counts as edge 1. The result for the window that the sample completes is visible just after edge N.
- R6: With PIPELINED=0, the result for a window is visible just after the same edge that accepted the sample that completes it.
- R7: Once the window is full, each accepted sample produces exactly one result with medVld high. medVld is never high otherwise.
- R8: While rst is high at a rising edge, the window and the fill count clear. After that edge, medVld is 0 and medOut is 0 until new results arrive, and filling (R1) starts over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inVld | input | 1 | Sample strobe; the sample is accepted at the rising edge |
| inSample | input | N | Unsigned sample value |
| medVld | output | 1 | High for one cycle per median result |
| medOut | output | N | Median of the window, unsigned |

## Verification
The bench builds two copies of the block side by side.

The first copy is pipelined, with M=5 and N=8. It puts eight register levels between acceptance and result, so the exact N-cycle timing and the flushing of in-flight results by a mid-stream reset can be observed.

The second copy is combinational, with M=7 and N=4. Its narrow samples make repeated values and ties in many bit columns common, so the split-flag logic is exercised hard. Its window also fills later than the first copy's, so the fill gate is checked at two different depths from the same stimulus.

// File: rtl/median_pkg.sv
package median_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;  // accept sample into the window
    logic emitVld;  // this accept completes a full window
  } medCtrl_t;
endpackage

// File: rtl/median_vote.sv
module median_vote #(
  parameter int M = 5
) (
  input  logic [M-1:0] ballots,
  output logic         vote
);
  localparam int CW = $clog2(M + 1);

  logic [CW-1:0] tally;

  always_comb begin
    tally = '0;
    for (int j = 0; j < M; j++) begin
      tally = tally + {{(CW-1){1'b0}}, ballots[j]};
    end
  end

  // odd M: more ones than zeros means tally above M/2
  assign vote = (tally > CW'(M / 2));
endmodule

// File: rtl/median_ctrl.sv
module median_ctrl
  import median_pkg::*;
#(
  parameter int M = 5
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     inVld,
  output medCtrl_t ctrl
);
  localparam int            CW      = $clog2(M + 1);
  localparam logic [CW-1:0] FILL_MAX = CW'(M);
  localparam logic [CW-1:0] LAST_GAP = CW'(M - 1);

  logic [CW-1:0] fillCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt <= '0;
    end else if (inVld && (fillCnt != FILL_MAX)) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  always_comb begin
    ctrl.shiftEn = inVld;
    ctrl.emitVld = inVld && (fillCnt >= LAST_GAP);
  end
endmodule

// File: rtl/median_dp.sv
module median_dp
  import median_pkg::*;
#(
  parameter int M    = 5,
  parameter int N    = 8,
  parameter bit PIPE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  medCtrl_t     ctrl,
  input  logic [N-1:0] inSample,
  output logic         medVld,
  output logic [N-1:0] medOut
);
  logic [M-1:0][N-1:0] winReg;
  logic                vld0;

  always_ff @(posedge clk) begin
    if (rst) begin
      winReg <= '0;
      vld0   <= 1'b0;
    end else begin
      vld0 <= ctrl.emitVld;
      if (ctrl.shiftEn) begin
        winReg <= {winReg[M-2:0], inSample};
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : stg
    localparam int BIT = N - 1 - i;

    logic [M-1:0][BIT:0] winIn;
    logic [M-1:0]        divIn, heldIn, colBit, effBit;
    logic [N-1:0]        medIn, medNxt;
    logic                vldIn, vote;

    if (i == 0) begin : head
      assign winIn  = winReg;
      assign divIn  = '0;
      assign heldIn = '0;
      assign medIn  = '0;
      assign vldIn  = vld0;
    end else begin : link
      assign winIn  = stg[i-1].fwd.winOut;
      assign divIn  = stg[i-1].fwd.divOut;
      assign heldIn = stg[i-1].fwd.heldOut;
      assign medIn  = stg[i-1].fwd.medFwd;
      assign vldIn  = stg[i-1].fwd.vldOut;
    end

    always_comb begin
      for (int j = 0; j < M; j++) begin
        colBit[j] = winIn[j][BIT];
      end
    end

    // split samples vote with their held bit, others with their own bit
    assign effBit = (divIn & heldIn) | (~divIn & colBit);

    median_vote #(.M(M)) u_vote (
      .ballots(effBit),
      .vote   (vote)
    );

    always_comb begin
      medNxt      = medIn;
      medNxt[BIT] = vote;
    end

    if (i < N - 1) begin : fwd
      logic [M-1:0][BIT-1:0] winNxt, winOut;
      logic [M-1:0]          divNxt, divOut, heldOut;
      logic [N-1:0]          medFwd;
      logic                  vldOut;

      always_comb begin
        for (int j = 0; j < M; j++) begin
          winNxt[j] = winIn[j][BIT-1:0];
        end
      end

      assign divNxt = divIn | (effBit ^ {M{vote}});

      if (PIPE) begin : pipe
        always_ff @(posedge clk) begin
          if (rst) begin
            winOut  <= '0;
            divOut  <= '0;
            heldOut <= '0;
            medFwd  <= '0;
            vldOut  <= 1'b0;
          end else begin
            winOut  <= winNxt;
            divOut  <= divNxt;
            heldOut <= effBit;
            medFwd  <= medNxt;
            vldOut  <= vldIn;
          end
        end
      end else begin : flat
        assign winOut  = winNxt;
        assign divOut  = divNxt;
        assign heldOut = effBit;
        assign medFwd  = medNxt;
        assign vldOut  = vldIn;
      end
    end else begin : tail
      assign medVld = vldIn;
      assign medOut = medNxt;
    end
  end
endmodule

// File: rtl/median_filter.sv
module median_filter
  import median_pkg::*;
#(
  parameter int M         = 5,
  parameter int N         = 8,
  parameter bit PIPELINED = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inVld,
  input  logic [N-1:0] inSample,
  output logic         medVld,
  output logic [N-1:0] medOut
);
  medCtrl_t ctrl;

  median_ctrl #(.M(M)) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .inVld(inVld),
    .ctrl (ctrl)
  );

  median_dp #(.M(M), .N(N), .PIPE(PIPELINED)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .inSample(inSample),
    .medVld  (medVld),
    .medOut  (medOut)
  );
endmodule

// File: rtl/median_filter_chk.sv
module median_filter_chk #(
  parameter int M         = 5,
  parameter int N         = 8,
  parameter bit PIPELINED = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic         inVld,
  input logic [N-1:0] inSample,
  input logic         medVld,
  input logic [N-1:0] medOut
);
  localparam int LAT  = PIPELINED ? N : 1;
  localparam int HALF = (M + 1) / 2;
  localparam int CW   = $clog2(M + 1);

  logic [CW-1:0]       seen;
  logic [LAT-1:0]      hv;
  logic [M-1:0][N-1:0] hw [LAT];
  int                  geCnt, leCnt;
  logic                allSame;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= '0;
      hv   <= '0;
      for (int j = 0; j < LAT; j++) hw[j] <= '0;
    end else begin
      if (inVld && (seen != CW'(M))) seen <= seen + 1'b1;
      hv[0] <= inVld && (seen >= CW'(M - 1));
      if (inVld) hw[0] <= {hw[0][M-2:0], inSample};
      for (int j = 1; j < LAT; j++) begin
        hv[j] <= hv[j-1];
        hw[j] <= hw[j-1];
      end
    end
  end

  always_comb begin
    geCnt   = 0;
    leCnt   = 0;
    allSame = 1'b1;
    for (int j = 0; j < M; j++) begin
      if (hw[LAT-1][j] >= medOut) geCnt++;
      if (hw[LAT-1][j] <= medOut) leCnt++;
      if (hw[LAT-1][j] != hw[LAT-1][0]) allSame = 1'b0;
    end
  end

  // R1
  fill_gate_chk: assert property (@(posedge clk) disable iff (rst)
    medVld |-> (seen == CW'(M)));

  // R5 R6 R7
  result_timing_chk: assert property (@(posedge clk) disable iff (rst)
    medVld == hv[LAT-1]);

  // R3
  median_rank_chk: assert property (@(posedge clk) disable iff (rst)
    medVld |-> ((geCnt >= HALF) && (leCnt >= HALF)));

  // R4
  uniform_window_chk: assert property (@(posedge clk) disable iff (rst)
    (medVld && allSame) |-> (medOut == hw[LAT-1][0]));
endmodule

bind median_filter median_filter_chk #(.M(M), .N(N), .PIPELINED(PIPELINED)) chk (
  .clk     (clk),
  .rst     (rst),
  .inVld   (inVld),
  .inSample(inSample),
  .medVld  (medVld),
  .medOut  (medOut)
);

// File: tb/median_filter_test.sv
module median_filter_test;
  localparam int MA = 5, NA = 8, MB = 7, NB = 4;
  localparam int LATA = NA, LATB = 1;

  logic clk = 1'b0, rst = 1'b1, inVld = 1'b0;
  logic [NA-1:0] sA = '0, outA;
  logic [NB-1:0] sB = '0, outB;
  logic vldA, vldB;

  int cyc = 0;
  int nCmp = 0, nBad = 0;
  int winA[$], winB[$], expA[$], dueA[$], expB[$], dueB[$];
  string curTag = "R3 start";

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  median_filter #(.M(MA), .N(NA), .PIPELINED(1'b1)) uut (
    .clk(clk), .rst(rst), .inVld(inVld), .inSample(sA),
    .medVld(vldA), .medOut(outA));

  median_filter #(.M(MB), .N(NB), .PIPELINED(1'b0)) uutFlat (
    .clk(clk), .rst(rst), .inVld(inVld), .inSample(sB),
    .medVld(vldB), .medOut(outB));

  function automatic int medianOf(int w[$]);
    int s[$];
    s = w;
    s.sort();
    return s[s.size() / 2];
  endfunction

  task automatic check(string tag, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(int v);
    @(negedge clk);
    #1;
    inVld = 1'b1;
    sA = v[NA-1:0];
    sB = v[NB-1:0];
    winA.push_front(v & 255);
    if (winA.size() > MA) void'(winA.pop_back());
    if (winA.size() == MA) begin
      expA.push_back(medianOf(winA));
      dueA.push_back(cyc + LATA);
    end
    winB.push_front(v & 15);
    if (winB.size() > MB) void'(winB.pop_back());
    if (winB.size() == MB) begin
      expB.push_back(medianOf(winB));
      dueB.push_back(cyc + LATB);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
      inVld = 1'b0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    #1;
    rst = 1'b1;
    inVld = 1'b0;
    winA.delete(); winB.delete();
    expA.delete(); dueA.delete(); expB.delete(); dueB.delete();
    repeat (3) @(negedge clk);
    check("R8 reset medVld A", vldA, 0);
    check("R8 reset medOut A", outA, 0);
    check("R8 reset medVld B", vldB, 0);
    check("R8 reset medOut B", outB, 0);
    #1;
    rst = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (vldA) begin
        if (expA.size() == 0) check("R1 R7 unexpected A result", 1, 0);
        else begin
          check({curTag, " A value"}, outA, expA.pop_front());
          check("R5 A latency", cyc, dueA.pop_front());
        end
      end else if (dueA.size() > 0 && dueA[0] <= cyc) begin
        check("R7 missing A result", 0, 1);
        void'(expA.pop_front());
        void'(dueA.pop_front());
      end
      if (vldB) begin
        if (expB.size() == 0) check("R1 R7 unexpected B result", 1, 0);
        else begin
          check({curTag, " B value"}, outB, expB.pop_front());
          check("R6 B latency", cyc, dueB.pop_front());
        end
      end else if (dueB.size() > 0 && dueB[0] <= cyc) begin
        check("R7 missing B result", 0, 1);
        void'(expB.pop_front());
        void'(dueB.pop_front());
      end
    end
  end

  initial begin
    #(8 * 150000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    doReset();

    // R1: partial fill gives no result
    curTag = "R1 fill";
    for (int k = 0; k < MA - 1; k++) push(10 + 20 * k);
    idle(LATA + 3);
    check("R1 partial fill A", vldA, 0);
    check("R1 partial fill B", vldB, 0);
    push(3);
    idle(LATA + 3);
    check("R7 single result drained A", expA.size(), 0);
    push(200); push(201);
    idle(LATA + 3);
    check("R7 B filled drained", expB.size(), 0);

    // R2: gaps between accepts
    curTag = "R2 gaps";
    for (int k = 0; k < 40; k++) begin
      push($urandom_range(0, 255));
      idle($urandom_range(0, 3));
    end

    // R3: back-to-back random
    curTag = "R3 random";
    for (int k = 0; k < 300; k++) push($urandom_range(0, 255));

    // R3: many repeats
    curTag = "R3 repeats";
    for (int k = 0; k < 120; k++) push(17 * $urandom_range(0, 2));

    // R4: uniform windows
    curTag = "R4 zeros";
    for (int k = 0; k < 12; k++) push(0);
    curTag = "R4 ones";
    for (int k = 0; k < 12; k++) push(255);
    curTag = "R4 mid";
    for (int k = 0; k < 10; k++) push(90);

    // R3: ramps
    curTag = "R3 ramp";
    for (int k = 0; k < 40; k++) push(k * 6);
    for (int k = 40; k > 0; k--) push(k * 6);
    idle(LATA + 3);
    check("R7 drained after stream A", expA.size(), 0);
    check("R7 drained after stream B", expB.size(), 0);

    // R8: mid-stream reset flushes and restarts fill
    curTag = "R8 restart";
    for (int k = 0; k < 6; k++) push($urandom_range(0, 255));
    doReset();
    for (int k = 0; k < MA - 1; k++) push(250 - k);
    idle(LATA + 3);
    check("R8 R1 refill A", vldA, 0);
    check("R8 R1 refill B", vldB, 0);
    curTag = "R3 after reset";
    for (int k = 0; k < 60; k++) push($urandom_range(0, 255));
    idle(LATA + 4);
    check("R7 final drain A", expA.size(), 0);
    check("R7 final drain B", expB.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule